// File: doc/BRIEF.md
# Affector History Index Former

This block sits in the lookup path of a corrector branch predictor. For each branch it receives the long global outcome history and a bitmap that marks which of those history positions are affectors. Affectors are earlier branches whose outcomes steered the computation feeding this branch's operands. The block selects the affector outcomes, hashes them down and registers a table index and a tag for the corrector table.

Two selection styles are available, chosen per request. Zeroing keeps each selected outcome at its original history position and forces every other position to zero. Packing squeezes the selected outcomes together toward bit 0. Both results are reduced by an XOR fold to a 19-bit hash. The hash is then cut into an index field and a tag field.

Top module: `afx_index_former`

## Requirements
- R1: While reset is high at a clock edge, and afterwards until the first accepted request, out_valid, out_idx and out_tag are all zero.
- R2: out_valid equals the in_valid value sampled at the previous rising clock edge, so every result appears one cycle after its request.
- R3: When in_mode is 0 (zeroing), the selected vector is in_hist AND in_amap, and every bit stays at its history position.
- R4: When in_mode is 1 (packing), the history bits at positions where in_amap is 1 are placed at bits 0, 1, 2, and so on. They go in order of increasing history position, so the most recent affector lands at bit 0. All higher bits are zero.
- R5: The selected 64-bit vector is split into 19-bit chunks starting at bit 0. The last chunk is padded with zeros, and the chunks are XORed together, so vector bit i contributes to hash bit i mod 19.
- R6: out_idx is hash bits 8:0 and out_tag is hash bits 18:9.
- R7: A request with an all-zero in_amap yields out_idx 0 and out_tag 0 in both modes, whatever in_hist holds.
- R8: A cycle with in_valid low leaves out_idx and out_tag unchanged and drives out_valid low on the next cycle.
- R9: History bits at positions where in_amap is 0 have no effect on out_idx or out_tag in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 1 | 0 selects zeroing, 1 selects packing |
| in_hist | input | 64 | Global outcome history, bit 0 the most recent branch |
| in_amap | input | 64 | Affector bitmap aligned with in_hist |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_idx | output | 9 | Corrector table index |
| out_tag | output | 10 | Corrector table tag |

## Verification
Each request's index, tag and valid flag are due exactly one rising edge after the request is presented. A hold cycle with in_valid low shows up at the outputs after that same single edge. The bench drives each request on a falling edge and lets one rising edge pass. It then compares against its model on the next falling edge, before presenting anything new. The model itself advances once per request, so every output is checked on every clock against the value that request should produce.

// File: rtl/afx_pkg.sv
package afx_pkg;

    localparam int HIST_W = 64;
    localparam int IDX_W  = 9;
    localparam int TAG_W  = 10;
    localparam int HASH_W = IDX_W + TAG_W;

    typedef enum logic {
        SEL_ZERO = 1'b0,
        SEL_PACK = 1'b1
    } sel_mode_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
    } hash_t;

endpackage

// File: rtl/afx_select.sv
module afx_select #(
    parameter int HW = afx_pkg::HIST_W
) (
    input  logic [HW-1:0]      hist,
    input  logic [HW-1:0]      amap,
    input  afx_pkg::sel_mode_e mode,
    output logic [HW-1:0]      sel_vec
);
    logic [HW-1:0] masked;
    logic [HW-1:0] packed_v;

    assign masked = hist & amap;

    // compaction: each marked position goes to the next free slot from bit 0
    always_comb begin
        int slot;
        slot     = 0;
        packed_v = '0;
        for (int i = 0; i < HW; i++) begin
            if (amap[i]) begin
                packed_v[slot] = hist[i];
                slot = slot + 1;
            end
        end
    end

    assign sel_vec = (mode == afx_pkg::SEL_PACK) ? packed_v : masked;
endmodule

// File: rtl/afx_fold.sv
module afx_fold #(
    parameter int IN_W  = afx_pkg::HIST_W,
    parameter int OUT_W = afx_pkg::HASH_W
) (
    input  logic [IN_W-1:0]  vec,
    output logic [OUT_W-1:0] hash
);
    localparam int NCH   = (IN_W + OUT_W - 1) / OUT_W;
    localparam int PAD_W = NCH * OUT_W;

    logic [PAD_W-1:0] padded;
    logic [OUT_W-1:0] acc [NCH];

    assign padded = PAD_W'(vec);
    assign acc[0] = padded[OUT_W-1:0];

    for (genvar c = 1; c < NCH; c++) begin : g_chunk
        assign acc[c] = acc[c-1] ^ padded[c*OUT_W +: OUT_W];
    end

    assign hash = acc[NCH-1];
endmodule

// File: rtl/afx_index_former.sv
module afx_index_former (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_mode,
    input  logic [afx_pkg::HIST_W-1:0] in_hist,
    input  logic [afx_pkg::HIST_W-1:0] in_amap,
    output logic                       out_valid,
    output logic [afx_pkg::IDX_W-1:0]  out_idx,
    output logic [afx_pkg::TAG_W-1:0]  out_tag
);
    import afx_pkg::*;

    sel_mode_e            mode;
    logic [HIST_W-1:0]    sel_vec;
    logic [HASH_W-1:0]    hash_raw;
    hash_t                hash_q;
    logic                 valid_q;

    assign mode = sel_mode_e'(in_mode);

    afx_select #(.HW(HIST_W)) u_select (
        .hist    (in_hist),
        .amap    (in_amap),
        .mode    (mode),
        .sel_vec (sel_vec)
    );

    afx_fold #(.IN_W(HIST_W), .OUT_W(HASH_W)) u_fold (
        .vec  (sel_vec),
        .hash (hash_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            hash_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                hash_q <= hash_t'(hash_raw);
            end
        end
    end

    assign out_valid = valid_q;
    assign out_idx   = hash_q.idx;
    assign out_tag   = hash_q.tag;

    // R3
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == SEL_ZERO) |-> ((sel_vec & ~in_amap) == '0));

    // R4
    pack_count_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == SEL_PACK) |-> ($countones(sel_vec) == $countones(in_hist & in_amap)));

    // R4
    pack_align_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == SEL_PACK) |-> ((sel_vec >> $countones(in_amap)) == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    empty_map_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_amap == '0) |=> (out_idx == '0 && out_tag == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_idx) && $stable(out_tag) && !out_valid));
endmodule

// File: tb/afx_index_former_bench.sv
module afx_index_former_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [63:0] in_hist = '0;
    logic [63:0] in_amap = '0;
    logic        out_valid;
    logic [8:0]  out_idx;
    logic [9:0]  out_tag;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic        exp_valid = 1'b0;
    logic [8:0]  exp_idx = '0;
    logic [9:0]  exp_tag = '0;

    afx_index_former u_afx_index_former (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_hist(in_hist), .in_amap(in_amap),
        .out_valid(out_valid), .out_idx(out_idx), .out_tag(out_tag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [63:0] ref_select(logic [63:0] h, logic [63:0] m, logic pk);
        bit q[$];
        logic [63:0] r;
        r = '0;
        if (!pk) return h & m;
        for (int i = 0; i < 64; i++) if (m[i]) q.push_back(h[i]);
        for (int j = 0; j < q.size(); j++) r[j] = q[j];
        return r;
    endfunction

    function automatic logic [18:0] ref_fold(logic [63:0] v);
        logic [18:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) r[i % 19] = r[i % 19] ^ v[i];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic compare_all(string req);
        check(req, 32'(out_valid), 32'(exp_valid), "out_valid");
        check(req, 32'(out_idx),   32'(exp_idx),   "out_idx");
        check(req, 32'(out_tag),   32'(exp_tag),   "out_tag");
    endtask

    // drive at a falling edge, one rising edge, compare at the next falling edge
    task automatic step(string req, logic v, logic pk, logic [63:0] h, logic [63:0] m);
        logic [18:0] hs;
        in_valid = v; in_mode = pk; in_hist = h; in_amap = m;
        exp_valid = v;
        if (v) begin
            hs = ref_fold(ref_select(h, m, pk));
            exp_idx = hs[8:0];
            exp_tag = hs[18:9];
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        logic [8:0] keep_idx;
        logic [9:0] keep_tag;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        compare_all("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        compare_all("R1 after reset");

        // R3 zeroing keeps position: bit 5 -> idx bit 5
        step("R3", 1, 0, '1, 64'h20);
        check("R3", 32'(out_idx), 32'h20, "idx bit5");
        // R5 fold: bit 20 -> hash bit 1, bit 40 -> bit 2, bit 57 -> bit 0
        step("R5", 1, 0, '1, 64'd1 << 20);
        check("R5", 32'(out_idx), 32'h2, "idx bit20");
        step("R5", 1, 0, '1, 64'd1 << 40);
        check("R5", 32'(out_idx), 32'h4, "idx bit40");
        step("R5", 1, 0, '1, 64'd1 << 57);
        check("R5", 32'(out_idx), 32'h1, "idx bit57");
        // R6: hash bit 18 is tag bit 9, bit 9 is tag bit 0
        step("R6", 1, 0, '1, 64'd1 << 18);
        check("R6", 32'(out_tag), 32'h200, "tag bit18");
        step("R6", 1, 0, '1, 64'd1 << 9);
        check("R6", 32'(out_tag), 32'h1, "tag bit9");
        check("R6", 32'(out_idx), 32'h0, "idx bit9");
        // R4 packing: affectors at 10 and 40
        step("R4", 1, 1, 64'd1 << 10, (64'd1 << 10) | (64'd1 << 40));
        check("R4", 32'(out_idx), 32'h1, "pack lower");
        step("R4", 1, 1, 64'd1 << 40, (64'd1 << 10) | (64'd1 << 40));
        check("R4", 32'(out_idx), 32'h2, "pack upper");
        step("R4", 1, 1, '1, 64'hFFFF_0000_0000_0000);
        check("R4", 32'(out_idx), 32'h1FF, "pack 16 ones idx");
        // R7 empty map in both modes
        step("R7", 1, 0, 64'hDEAD_BEEF_1234_5678, '0);
        check("R7", 32'({out_tag, out_idx}), 32'h0, "zero mode");
        step("R7", 1, 1, 64'hDEAD_BEEF_1234_5678, '0);
        check("R7", 32'({out_tag, out_idx}), 32'h0, "pack mode");
        // R9 non-affector history ignored
        step("R9", 1, 0, 64'h0000_0000_0000_00F0, 64'h0F0F_0000_0000_00F0);
        keep_idx = out_idx; keep_tag = out_tag;
        step("R9", 1, 0, 64'hF0F0_FFFF_FFFF_FF0F | 64'h00F0, 64'h0F0F_0000_0000_00F0);
        check("R9", 32'({out_tag, out_idx}), 32'({keep_tag, keep_idx}), "zero ignore");
        step("R9", 1, 1, 64'h0000_0000_0000_00F0, 64'h0F0F_0000_0000_00F0);
        keep_idx = out_idx; keep_tag = out_tag;
        step("R9", 1, 1, 64'hF0F0_FFFF_FFFF_FFFF, 64'h0F0F_0000_0000_00F0);
        check("R9", 32'({out_tag, out_idx}), 32'({keep_tag, keep_idx}), "pack ignore");
        // R8 hold with in_valid low
        keep_idx = out_idx; keep_tag = out_tag;
        step("R8", 0, 1, '1, '1);
        check("R8", 32'({out_tag, out_idx}), 32'({keep_tag, keep_idx}), "hold");
        step("R8", 0, 0, 64'h1234, '1);
        // R2 back-to-back and mixed traffic
        for (int n = 0; n < 300; n++) begin
            logic [63:0] h, m;
            h = {$urandom, $urandom};
            m = {$urandom, $urandom} & {$urandom, $urandom};
            step("R2", ($urandom % 4) != 0, n[0], h, m);
        end
        rst = 1'b1;
        exp_valid = 0; exp_idx = '0; exp_tag = '0;
        @(posedge clk); @(negedge clk);
        compare_all("R1 reset again");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule